// File: doc/BRIEF.md
# Power Mode Sequencer

This block tracks which operating mode a small microcontroller is in and drives the controls that follow from it. The CPU reports WAIT and STOP instructions as one-cycle strobes, an interrupt controller reports pending requests, and a register bus sets the configuration. From these the sequencer moves between full-speed run, reduced-regulation run, the two wait states and two stop depths. Its outputs are the current mode code, the CPU and bus clock enables, the regulator state, a hint that reference clocks must keep running, a low-power status flag and a one-cycle illegal-instruction reset request.

The stop depth is chosen once, on the cycle the STOP strobe arrives. A fixed priority decides it: debug enable comes first, then the pair of voltage-monitor enables, then the powerdown selector. The wait-exit target is likewise captured when the WAIT strobe arrives.

Configuration register (read and write, bus data bit positions): bit 0 stop permit, bit 1 voltage-monitor enable, bit 2 voltage-monitor-in-stop enable, bit 3 deep-stop select, bit 4 low-power run request, bit 5 full wake-up select, bit 6 reads 0, bit 7 reads the low-power status flag and ignores writes.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode is 0 (run), both clock enables are 1, regulator is 0 (full), the reference-keep, status flag and illegal reset outputs are 0, and the configuration reads 0x00.
- R2: A STOP strobe while the stop permit (bit 0) is 0 gives a one-cycle pulse on illop_rst in the next cycle and leaves the mode unchanged.
- R3: With stop permitted and dbg_en high, STOP enters mode 4 (stop3), regulator 0 (full) and ref_clk_keep 1, with both clock enables 0.
- R4: With stop permitted, dbg_en low and both voltage-monitor bits (1 and 2) set, STOP enters mode 4 with regulator 0 and ref_clk_keep 0, clocks off.
- R5: With stop permitted, dbg_en low and either voltage-monitor bit clear, STOP enters mode 4 with regulator 1 (standby) when bit 3 is 0, or mode 5 (stop2) with regulator 2 (partial powerdown) when bit 3 is 1. Clocks are off in both.
- R6: In run mode with bit 4 set, the next cycle is mode 1 (low-power run): regulator 1, clocks on, status flag 1 (also read at bit 7). Clearing bit 4 returns the block to mode 0.
- R7: WAIT from mode 0 enters mode 2: CPU clock 0, bus clock 1, regulator 0. An interrupt returns to mode 0.
- R8: WAIT from mode 1 with bit 5 clear enters mode 3 (low-power wait): CPU clock 0, bus clock 1, regulator 1. An interrupt returns to mode 1.
- R9: WAIT from mode 1 with bit 5 set, and then an interrupt, returns to mode 0 and clears bit 4 and the status flag.
- R10: An interrupt in mode 4 returns to the run mode (0 or 1) from which STOP was executed.
- R11: An interrupt in mode 5 enters mode 6 (recovery) for one cycle, with regulator 0 and clocks off. The block then enters mode 0 with the configuration cleared to 0x00.
- R12: Once a stop mode is entered, later writes to bits 1 to 3 and changes of dbg_en alter neither the mode nor the regulator state.
- R13: Reset from mode 3 returns to mode 0 with bit 4 and the status flag cleared.
- R14: An interrupt in mode 0 or mode 1 has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_stb | input | 1 | WAIT instruction strobe |
| stop_stb | input | 1 | STOP instruction strobe |
| irq | input | 1 | Pending interrupt request |
| dbg_en | input | 1 | Debug enable |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | DATA_W (8) | Configuration write data |
| cfg_rdata | output | DATA_W (8) | Configuration read data, status in bit 7 |
| mode | output | 3 | Mode: 0 run, 1 low-power run, 2 wait, 3 low-power wait, 4 stop3, 5 stop2, 6 recovery |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| regulator | output | 2 | 0 full, 1 standby, 2 partial powerdown |
| ref_clk_keep | output | 1 | Reference clocks must stay running |
| lp_flag | output | 1 | Low-power status |
| illop_rst | output | 1 | Illegal-instruction reset pulse |

## Verification
The assertions assume that WAIT and STOP arrive as single-cycle strobes, never both in one cycle, and only while the CPU is running. The single-pulse check on the illegal reset depends on this, and so does the claim that an entered stop kind stays put. The bench raises each strobe and each interrupt for exactly one clock, and only in run modes. It resets the block between sweep points, so every STOP is issued from a settled run or low-power-run state. Configuration writes are allowed at any time, including during stop, because the block has to tolerate them.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MD_RUN    = 3'd0,
    MD_LPRUN  = 3'd1,
    MD_WAIT   = 3'd2,
    MD_LPWAIT = 3'd3,
    MD_STOP3  = 3'd4,
    MD_STOP2  = 3'd5,
    MD_RECOV  = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    RG_FULL = 2'd0,
    RG_STBY = 2'd1,
    RG_PPD  = 2'd2
  } reg_e;

  typedef enum logic [1:0] {
    SK_DBG   = 2'd0,
    SK_REGON = 2'd1,
    SK_STBY  = 2'd2,
    SK_DEEP  = 2'd3
  } stop_kind_e;

  // packed: first member is the MSB, so stop_ok lands on bit 0
  typedef struct packed {
    logic full_wake;
    logic lp_req;
    logic deep_sel;
    logic vmon_stop;
    logic vmon_en;
    logic stop_ok;
  } cfg_t;

  // fixed priority: debug, then voltage monitor pair, then depth select
  function automatic stop_kind_e pick_stop(logic dbg, logic vmon, logic vmon_stop,
                                           logic deep);
    if (dbg)                   return SK_DBG;
    else if (vmon && vmon_stop) return SK_REGON;
    else if (deep)             return SK_DEEP;
    else                       return SK_STBY;
  endfunction

  function automatic reg_e mode_regulator(mode_e m, stop_kind_e k);
    case (m)
      MD_LPRUN, MD_LPWAIT: return RG_STBY;
      MD_STOP2:            return RG_PPD;
      MD_STOP3:            return (k == SK_STBY) ? RG_STBY : RG_FULL;
      default:             return RG_FULL;
    endcase
  endfunction

  function automatic logic mode_is_lp(mode_e m);
    return (m == MD_LPRUN) || (m == MD_LPWAIT);
  endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_all,
  input  logic              clr_lp,
  input  logic              lp_flag,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rdata
);
  localparam int CFG_W = $bits(cfg_t);
  localparam int PAD_W = DATA_W - CFG_W - 1;

  cfg_t cfg_q;
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (clr_all) begin
      cfg_q <= '0;
    end else begin
      if (wr_en) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
      if (clr_lp) cfg_q.lp_req <= 1'b0;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {lp_flag, {PAD_W{1'b0}}, cfg_q};

  AST_RECOV_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) |-> (cfg_q == '0)); // R11
  AST_WAKE_DROPS_LPREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_lp) |-> !cfg_q.lp_req); // R9

endmodule

// File: rtl/pwr_stop_decode.sv
module pwr_stop_decode
  import pwr_mode_pkg::*;
(
  input  logic       dbg_en,
  input  logic       vmon_en,
  input  logic       vmon_stop,
  input  logic       deep_sel,
  output stop_kind_e kind
);
  assign kind = pick_stop(dbg_en, vmon_en, vmon_stop, deep_sel);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_stb,
  input  logic       stop_stb,
  input  logic       irq,
  input  logic       stop_ok,
  input  logic       lp_req,
  input  logic       full_wake,
  input  stop_kind_e kind_in,
  output mode_e      mode,
  output logic       cpu_clk_en,
  output logic       bus_clk_en,
  output reg_e       regulator,
  output logic       ref_clk_keep,
  output logic       lp_flag,
  output logic       illop_rst,
  output logic       clr_lp,
  output logic       clr_all
);
  mode_e      mode_q, mode_d;
  stop_kind_e kind_q, kind_d;
  logic       ret_lp_q, ret_lp_d;
  logic       illop_q;
  logic       lp_flag_q;

  // named events for the checks
  logic in_lp, stop_taken, illop_fire, wake_full, stop_wake;
  assign in_lp      = (mode_q == MD_LPRUN);
  assign stop_taken = ((mode_q == MD_RUN) || in_lp) && !wait_stb && stop_stb && stop_ok;
  assign illop_fire = ((mode_q == MD_RUN) || in_lp) && !wait_stb && stop_stb && !stop_ok;
  assign wake_full  = (mode_q == MD_LPWAIT) && irq && !ret_lp_q;
  assign stop_wake  = (mode_q == MD_STOP3) && irq;

  always_comb begin
    mode_d   = mode_q;
    kind_d   = kind_q;
    ret_lp_d = ret_lp_q;
    clr_lp   = 1'b0;
    clr_all  = 1'b0;
    case (mode_q)
      MD_RUN, MD_LPRUN: begin
        if (wait_stb) begin
          mode_d   = in_lp ? MD_LPWAIT : MD_WAIT;
          ret_lp_d = in_lp && !full_wake;
        end else if (stop_taken) begin
          kind_d   = kind_in;
          mode_d   = (kind_in == SK_DEEP) ? MD_STOP2 : MD_STOP3;
          ret_lp_d = in_lp;
        end else if (!in_lp && lp_req && !illop_fire) begin
          mode_d = MD_LPRUN;
        end else if (in_lp && !lp_req && !illop_fire) begin
          mode_d = MD_RUN;
        end
      end
      MD_WAIT: if (irq) mode_d = MD_RUN;
      MD_LPWAIT: begin
        if (irq) begin
          mode_d = ret_lp_q ? MD_LPRUN : MD_RUN;
          clr_lp = !ret_lp_q;
        end
      end
      MD_STOP3: if (irq) mode_d = ret_lp_q ? MD_LPRUN : MD_RUN;
      MD_STOP2: if (irq) mode_d = MD_RECOV;
      MD_RECOV: begin
        mode_d  = MD_RUN;
        clr_all = 1'b1;
      end
      default: mode_d = MD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_RUN;
      kind_q    <= SK_DBG;
      ret_lp_q  <= 1'b0;
      illop_q   <= 1'b0;
      lp_flag_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      kind_q    <= kind_d;
      ret_lp_q  <= ret_lp_d;
      illop_q   <= illop_fire;
      lp_flag_q <= mode_is_lp(mode_d);
    end
  end

  assign mode         = mode_q;
  assign cpu_clk_en   = (mode_q == MD_RUN) || (mode_q == MD_LPRUN);
  assign bus_clk_en   = cpu_clk_en || (mode_q == MD_WAIT) || (mode_q == MD_LPWAIT);
  assign regulator    = mode_regulator(mode_q, kind_q);
  assign ref_clk_keep = (mode_q == MD_STOP3) && (kind_q == SK_DBG);
  assign lp_flag      = lp_flag_q;
  assign illop_rst    = illop_q;

  AST_ILLOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    illop_q |=> !illop_q); // R2
  AST_ILLOP_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    illop_q |-> $stable(mode_q)); // R2
  AST_STOP_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_STOP3 && $past(mode_q) == MD_STOP3) |-> $stable(kind_q)); // R12
  AST_LP_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    lp_flag_q == mode_is_lp(mode_q)); // R6
  AST_FULL_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_full |=> (mode_q == MD_RUN)); // R9
  AST_STOP3_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wake |=> cpu_clk_en); // R10
  AST_RECOV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RECOV) |=> (mode_q == MD_RUN)); // R11
  AST_STOP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stop_taken |=> (!cpu_clk_en && !bus_clk_en)); // R5

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_stb,
  input  logic              stop_stb,
  input  logic              irq,
  input  logic              dbg_en,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [2:0]        mode,
  output logic              cpu_clk_en,
  output logic              bus_clk_en,
  output logic [1:0]        regulator,
  output logic              ref_clk_keep,
  output logic              lp_flag,
  output logic              illop_rst
);
  cfg_t       cfg;
  stop_kind_e kind;
  mode_e      mode_w;
  reg_e       reg_w;
  logic       clr_lp, clr_all, lp_flag_w;

  pwr_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wdata(cfg_wdata),
    .clr_all(clr_all), .clr_lp(clr_lp), .lp_flag(lp_flag_w),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  pwr_stop_decode u_dec (
    .dbg_en(dbg_en), .vmon_en(cfg.vmon_en), .vmon_stop(cfg.vmon_stop),
    .deep_sel(cfg.deep_sel), .kind(kind)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .stop_stb(stop_stb), .irq(irq),
    .stop_ok(cfg.stop_ok), .lp_req(cfg.lp_req), .full_wake(cfg.full_wake),
    .kind_in(kind), .mode(mode_w), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .regulator(reg_w), .ref_clk_keep(ref_clk_keep), .lp_flag(lp_flag_w),
    .illop_rst(illop_rst), .clr_lp(clr_lp), .clr_all(clr_all)
  );

  assign mode      = mode_w;
  assign regulator = reg_w;
  assign lp_flag   = lp_flag_w;

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_stb = 0, stop_stb = 0, irq = 0, dbg_en = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [2:0] mode;
  logic [1:0] regulator;
  logic cpu_clk_en, bus_clk_en, ref_clk_keep, lp_flag, illop_rst;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_seq u_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .stop_stb(stop_stb), .irq(irq),
    .dbg_en(dbg_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .regulator(regulator), .ref_clk_keep(ref_clk_keep), .lp_flag(lp_flag),
    .illop_rst(illop_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1; cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  task automatic p_wait(); wait_stb = 1; cyc(); wait_stb = 0; endtask
  task automatic p_stop(); stop_stb = 1; cyc(); stop_stb = 0; endtask
  task automatic p_irq();  irq = 1;      cyc(); irq = 0;      endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 bus", bus_clk_en, 1);
    chk("R1 reg", regulator, 0);
    chk("R1 flags", {ref_clk_keep, lp_flag, illop_rst}, 0);
    chk("R1 cfg", cfg_rdata, 0);
    // R14 interrupt in run
    p_irq(); chk("R14 run irq", mode, 0);
    // R7 plain wait
    p_wait();
    chk("R7 mode", mode, 2);
    chk("R7 clocks", {cpu_clk_en, bus_clk_en}, 1);
    chk("R7 reg", regulator, 0);
    p_irq(); chk("R7 wake", mode, 0);
    // R6 low-power run
    wr(8'h10); cyc();
    chk("R6 mode", mode, 1);
    chk("R6 reg", regulator, 1);
    chk("R6 clocks", {cpu_clk_en, bus_clk_en}, 3);
    chk("R6 status", cfg_rdata[7], 1);
    p_irq(); chk("R14 lprun irq", mode, 1);
    // R8 low-power wait back to low-power run
    p_wait();
    chk("R8 mode", mode, 3);
    chk("R8 clocks", {cpu_clk_en, bus_clk_en}, 1);
    chk("R8 reg", regulator, 1);
    p_irq(); chk("R8 wake", mode, 1);
    // R9 full wake
    wr(8'h30); cyc();
    chk("R9 pre", mode, 1);
    p_wait(); chk("R9 wait", mode, 3);
    p_irq();
    chk("R9 wake", mode, 0);
    chk("R9 cfg", cfg_rdata, 8'h20);
    chk("R9 flag", lp_flag, 0);
    cyc(); chk("R9 stays", mode, 0);
    // R6 leaving low-power run
    wr(8'h10); cyc(); chk("R6 enter", mode, 1);
    wr(8'h00); cyc();
    chk("R6 leave", mode, 0);
    chk("R6 flag clear", lp_flag, 0);
    // R13 reset from low-power wait
    wr(8'h10); cyc(); p_wait(); chk("R13 pre", mode, 3);
    do_reset();
    chk("R13 mode", mode, 0);
    chk("R13 cfg", cfg_rdata, 0);
    chk("R13 flag", lp_flag, 0);

    // stop selection sweep
    for (int org = 0; org < 2; org++) begin
      for (int v = 0; v < 32; v++) begin
        int dbg, sen, vm, vms, dp, hold_full, deep, exp_md, exp_rg;
        logic [7:0] c;
        dbg = v & 1; sen = (v >> 1) & 1; vm = (v >> 2) & 1;
        vms = (v >> 3) & 1; dp = (v >> 4) & 1;
        hold_full = dbg | (vm & vms);
        deep = (1 - hold_full) * dp;
        exp_md = 4 + deep;
        exp_rg = hold_full ? 0 : 1 + dp;
        c = 8'((org << 4) + (dp << 3) + (vms << 2) + (vm << 1) + sen);
        do_reset();
        dbg_en = dbg[0];
        wr(c); cyc();
        chk("R6 origin", mode, org);
        p_stop();
        if (sen == 0) begin
          chk("R2 pulse", illop_rst, 1);
          chk("R2 mode kept", mode, org);
          cyc();
          chk("R2 single", illop_rst, 0);
        end else begin
          chk(dbg ? "R3 mode" : (hold_full ? "R4 mode" : "R5 mode"), mode, exp_md);
          chk(dbg ? "R3 reg" : (hold_full ? "R4 reg" : "R5 reg"), regulator, exp_rg);
          chk("R3 ref keep", ref_clk_keep, dbg);
          chk("R5 clocks off", {cpu_clk_en, bus_clk_en}, 0);
          chk("R2 no pulse", illop_rst, 0);
          wr(c ^ 8'h0E); dbg_en = ~dbg_en; cyc();
          chk("R12 mode held", mode, exp_md);
          chk("R12 reg held", regulator, exp_rg);
          p_irq();
          if (deep == 0) begin
            chk("R10 wake", mode, org);
          end else begin
            chk("R11 recov", mode, 6);
            chk("R11 recov reg", regulator, 0);
            chk("R11 recov clk", {cpu_clk_en, bus_clk_en}, 0);
            cyc();
            chk("R11 run", mode, 0);
            chk("R11 cfg", cfg_rdata, 0);
          end
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule